// File: doc/BRIEF.md
# Burst Cycle Protocol Monitor

This block watches a 32-bit bus master port and sorts every acknowledged transfer by its 3-bit cycle-type tag. It keeps four saturating tallies (single reads, single writes, completed read bursts, completed write bursts). It follows the beat position inside an incrementing burst and flags any transfer sequence that breaks the burst rules. It drives nothing onto the bus. It sits beside the master as a passive observer, and its outputs feed debug or error logic.

The monitor looks at a transfer only in a cycle where both `cyc` and `ack` are high. The legal tags are 3'b000 for a classic single access, 3'b010 for an incrementing beat that is not the final one, and 3'b111 for the final beat. A burst is legal when it has exactly `BURST_LEN` beats: `BURST_LEN-1` beats tagged 010 followed by one beat tagged 111. The read or write direction of a burst comes from `we` on its final beat.

The sequencer has two states. **ST_IDLE** means no burst is open and the beat position is zero. **ST_BURST** means a burst is open and the position is non-zero. The transitions are:
- **open**: ST_IDLE to ST_BURST on a 010 beat.
- **advance**: ST_BURST to ST_BURST on a 010 beat while the position is below `BURST_LEN-1`.
- **close**: ST_BURST or ST_IDLE to ST_IDLE on a legal 111 beat.
- **abort**: any state to ST_IDLE on an error.
- **hold**: no change when no transfer is examined.

Top module: `burst_cycle_monitor`

## Requirements
- R1: Synchronous active-high `rst` clears all four counters, `err_pulse`, `err_sticky` and the beat position to zero.
- R2: A cycle without both `cyc` and `ack` high changes no counter, no position and raises no error, whatever `we` and `cti` carry.
- R3: An examined beat with tag 3'b000 while no burst is open adds one to `single_rd_cnt` when `we`=0, or to `single_wr_cnt` when `we`=1. The new value is visible after that clock edge.
- R4: `BURST_LEN-1` examined beats tagged 3'b010 followed by one tagged 3'b111 add one to `burst_rd_cnt` (`we`=0 on the final beat) or to `burst_wr_cnt` (`we`=1). The position then returns to zero. No intermediate beat is counted.
- R5: An examined tag 3'b000 while the position is non-zero is an error. It is not counted, and the position returns to zero.
- R6: An examined tag 3'b111 while the position differs from `BURST_LEN-1` is an error. No burst is counted, and the position returns to zero.
- R7: An examined tag 3'b010 while the position equals `BURST_LEN-1` (a burst that is too long) is an error, and the position returns to zero.
- R8: An examined beat with any tag other than 000, 010 or 111 is an error, and the position returns to zero.
- R9: Every error raises `err_pulse` for the one cycle after the offending edge and sets `err_sticky`. `err_sticky` stays high until reset.
- R10: Each counter stops at its maximum value (65535 at the default 16-bit width) and stays there until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc | input | 1 | Bus cycle in progress |
| we | input | 1 | Write enable (1 = write) |
| ack | input | 1 | Transfer acknowledge |
| cti | input | 3 | Cycle-type tag |
| single_rd_cnt | output | 16 | Single read tally |
| single_wr_cnt | output | 16 | Single write tally |
| burst_rd_cnt | output | 16 | Completed read burst tally |
| burst_wr_cnt | output | 16 | Completed write burst tally |
| err_pulse | output | 1 | One-cycle error strobe |
| err_sticky | output | 1 | Error flag held until reset |

## Verification
The beat position is not visible at the ports. A wrong position therefore shows up only on the next examined 000 or 111 beat, or on the beat that should close the burst. At that point the design either raises an error that should not appear or misses one, and a burst tally fails to move. For this reason every error scenario is followed at once by a full legal burst, whose count proves that the position really went back to zero. Counter faults show up one cycle after the examined edge.

// File: rtl/bcm_pkg.sv
package bcm_pkg;

    localparam logic [2:0] TAG_CLASSIC = 3'b000;
    localparam logic [2:0] TAG_INCR    = 3'b010;
    localparam logic [2:0] TAG_EOB     = 3'b111;

    typedef enum logic [2:0] {
        K_NONE,
        K_SINGLE,
        K_STEP,
        K_END,
        K_BAD
    } beat_kind_t;

    typedef enum logic {
        ST_IDLE,
        ST_BURST
    } seq_state_t;

    typedef struct packed {
        logic single_rd;
        logic single_wr;
        logic burst_rd;
        logic burst_wr;
        logic err;
    } bcm_evt_t;

endpackage

// File: rtl/bcm_decode.sv
module bcm_decode
    import bcm_pkg::*;
(
    input  logic       cyc,
    input  logic       ack,
    input  logic [2:0] cti,
    output beat_kind_t kind
);
    always_comb begin
        if (!(cyc && ack)) begin
            kind = K_NONE;
        end else begin
            unique case (cti)
                TAG_CLASSIC: kind = K_SINGLE;
                TAG_INCR:    kind = K_STEP;
                TAG_EOB:     kind = K_END;
                default:     kind = K_BAD;
            endcase
        end
    end
endmodule

// File: rtl/bcm_burst_fsm.sv
module bcm_burst_fsm
    import bcm_pkg::*;
#(
    parameter int BURST_LEN = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  beat_kind_t kind,
    input  logic       we,
    output bcm_evt_t   evt
);
    localparam int BEAT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
    localparam logic [BEAT_W-1:0] LAST_POS = BEAT_W'(BURST_LEN - 1);

    seq_state_t        state_q, state_d;
    logic [BEAT_W-1:0] beat_q, beat_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
        end
    end

    // next state and event outputs
    always_comb begin
        state_d = state_q;
        beat_d  = beat_q;
        evt     = '0;
        unique case (state_q)
            ST_IDLE: begin
                case (kind)
                    K_SINGLE: begin
                        evt.single_rd = !we;
                        evt.single_wr = we;
                    end
                    K_STEP: begin
                        if (beat_q == LAST_POS) begin
                            evt.err = 1'b1;
                        end else begin
                            state_d = ST_BURST;
                            beat_d  = beat_q + 1'b1;
                        end
                    end
                    K_END: begin
                        if (beat_q == LAST_POS) begin
                            evt.burst_rd = !we;
                            evt.burst_wr = we;
                        end else begin
                            evt.err = 1'b1;
                        end
                        beat_d = '0;
                    end
                    K_BAD: begin
                        evt.err = 1'b1;
                        beat_d  = '0;
                    end
                    default: ;
                endcase
            end
            ST_BURST: begin
                case (kind)
                    K_SINGLE: begin
                        evt.err = 1'b1;
                        state_d = ST_IDLE;
                        beat_d  = '0;
                    end
                    K_STEP: begin
                        if (beat_q == LAST_POS) begin
                            evt.err = 1'b1;
                            state_d = ST_IDLE;
                            beat_d  = '0;
                        end else begin
                            beat_d = beat_q + 1'b1;
                        end
                    end
                    K_END: begin
                        if (beat_q == LAST_POS) begin
                            evt.burst_rd = !we;
                            evt.burst_wr = we;
                        end else begin
                            evt.err = 1'b1;
                        end
                        state_d = ST_IDLE;
                        beat_d  = '0;
                    end
                    K_BAD: begin
                        evt.err = 1'b1;
                        state_d = ST_IDLE;
                        beat_d  = '0;
                    end
                    default: ;
                endcase
            end
        endcase
    end
endmodule

// File: rtl/bcm_sat_counter.sv
module bcm_sat_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (inc && (cnt != CNT_MAX)) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/burst_cycle_monitor.sv
module burst_cycle_monitor
    import bcm_pkg::*;
#(
    parameter int BURST_LEN = 4,
    parameter int CNT_W     = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cyc,
    input  logic             we,
    input  logic             ack,
    input  logic [2:0]       cti,
    output logic [CNT_W-1:0] single_rd_cnt,
    output logic [CNT_W-1:0] single_wr_cnt,
    output logic [CNT_W-1:0] burst_rd_cnt,
    output logic [CNT_W-1:0] burst_wr_cnt,
    output logic             err_pulse,
    output logic             err_sticky
);
    localparam int N_CNT = 4;

    beat_kind_t       kind;
    bcm_evt_t         evt;
    logic [N_CNT-1:0] inc_vec;
    logic [CNT_W-1:0] cnt_arr [N_CNT];

    bcm_decode u_dec (
        .cyc  (cyc),
        .ack  (ack),
        .cti  (cti),
        .kind (kind)
    );

    bcm_burst_fsm #(.BURST_LEN(BURST_LEN)) u_fsm (
        .clk  (clk),
        .rst  (rst),
        .kind (kind),
        .we   (we),
        .evt  (evt)
    );

    assign inc_vec = {evt.burst_wr, evt.burst_rd, evt.single_wr, evt.single_rd};

    for (genvar gi = 0; gi < N_CNT; gi++) begin : g_cnt
        bcm_sat_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk (clk),
            .rst (rst),
            .inc (inc_vec[gi]),
            .cnt (cnt_arr[gi])
        );
    end

    assign single_rd_cnt = cnt_arr[0];
    assign single_wr_cnt = cnt_arr[1];
    assign burst_rd_cnt  = cnt_arr[2];
    assign burst_wr_cnt  = cnt_arr[3];

    always_ff @(posedge clk) begin
        if (rst) begin
            err_pulse  <= 1'b0;
            err_sticky <= 1'b0;
        end else begin
            err_pulse <= evt.err;
            if (evt.err) begin
                err_sticky <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/bcm_checker.sv
module bcm_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             cyc,
    input logic             we,
    input logic             ack,
    input logic [2:0]       cti,
    input logic [CNT_W-1:0] single_rd_cnt,
    input logic [CNT_W-1:0] single_wr_cnt,
    input logic [CNT_W-1:0] burst_rd_cnt,
    input logic [CNT_W-1:0] burst_wr_cnt,
    input logic             err_pulse,
    input logic             err_sticky
);
    AST_IDLE_NO_ERR: assert property (@(posedge clk) disable iff (rst)
        !(cyc && ack) |=> !err_pulse); // R2

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !(cyc && ack) |=> ($stable(single_rd_cnt) && $stable(single_wr_cnt)
                           && $stable(burst_rd_cnt) && $stable(burst_wr_cnt))); // R2

    AST_SINGLE_WR_STEP: assert property (@(posedge clk) disable iff (rst)
        (cyc && ack && we && cti == 3'b000) |=>
            ((single_wr_cnt == $past(single_wr_cnt) + 1'b1) || err_pulse
             || (&$past(single_wr_cnt)))); // R3

    AST_BURST_NO_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (cyc && ack && cti != 3'b000) |=>
            ($stable(single_rd_cnt) && $stable(single_wr_cnt))); // R4

    AST_BAD_TAG_ERR: assert property (@(posedge clk) disable iff (rst)
        (cyc && ack && cti != 3'b000 && cti != 3'b010 && cti != 3'b111) |=> err_pulse); // R8

    AST_PULSE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> err_sticky); // R9

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        err_sticky |=> err_sticky); // R9

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (&single_wr_cnt) |=> (&single_wr_cnt)); // R10
endmodule

bind burst_cycle_monitor bcm_checker #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cyc           (cyc),
    .we            (we),
    .ack           (ack),
    .cti           (cti),
    .single_rd_cnt (single_rd_cnt),
    .single_wr_cnt (single_wr_cnt),
    .burst_rd_cnt  (burst_rd_cnt),
    .burst_wr_cnt  (burst_wr_cnt),
    .err_pulse     (err_pulse),
    .err_sticky    (err_sticky)
);

// File: tb/sim_burst_cycle_monitor.sv
`timescale 1ns/1ps
module sim_burst_cycle_monitor;
    localparam int LEN = 4;
    localparam int W   = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cyc = 1'b0;
    logic         we  = 1'b0;
    logic         ack = 1'b0;
    logic [2:0]   cti = 3'b000;
    logic [W-1:0] srd, swr, brd, bwr;
    logic         epulse, esticky;

    int checks = 0;
    int fails  = 0;
    int e_srd = 0, e_swr = 0, e_brd = 0, e_bwr = 0;

    always #2 clk = ~clk;

    burst_cycle_monitor #(.BURST_LEN(LEN), .CNT_W(W)) u0 (
        .clk(clk), .rst(rst), .cyc(cyc), .we(we), .ack(ack), .cti(cti),
        .single_rd_cnt(srd), .single_wr_cnt(swr),
        .burst_rd_cnt(brd), .burst_wr_cnt(bwr),
        .err_pulse(epulse), .err_sticky(esticky)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_counts(input string req);
        chk(req, "single_rd_cnt", int'(srd), e_srd);
        chk(req, "single_wr_cnt", int'(swr), e_swr);
        chk(req, "burst_rd_cnt",  int'(brd), e_brd);
        chk(req, "burst_wr_cnt",  int'(bwr), e_bwr);
    endtask

    // one cycle of stimulus; outputs sampled 1 ns after the edge
    task automatic beat(input logic c, input logic a, input logic w, input logic [2:0] t);
        @(negedge clk);
        cyc = c; ack = a; we = w; cti = t;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        beat(1'b0, 1'b0, 1'b0, 3'b000);
    endtask

    task automatic good_burst(input logic w);
        for (int i = 0; i < LEN - 1; i++) beat(1'b1, 1'b1, w, 3'b010);
        beat(1'b1, 1'b1, w, 3'b111);
        if (w) e_bwr++; else e_brd++;
    endtask

    task automatic t_reset();
        chk_counts("R1");
        chk("R1", "err_pulse", int'(epulse), 0);
        chk("R1", "err_sticky", int'(esticky), 0);
    endtask

    task automatic t_ignored();
        beat(1'b1, 1'b0, 1'b1, 3'b000);
        beat(1'b0, 1'b1, 1'b0, 3'b000);
        beat(1'b1, 1'b0, 1'b0, 3'b101);
        beat(1'b0, 1'b1, 1'b1, 3'b111);
        chk_counts("R2");
        chk("R2", "err_pulse", int'(epulse), 0);
        chk("R2", "err_sticky", int'(esticky), 0);
    endtask

    task automatic t_singles();
        beat(1'b1, 1'b1, 1'b0, 3'b000); e_srd++;
        chk("R3", "single_rd_cnt after read", int'(srd), e_srd);
        beat(1'b1, 1'b1, 1'b1, 3'b000); e_swr++;
        beat(1'b1, 1'b1, 1'b1, 3'b000); e_swr++;
        beat(1'b1, 1'b1, 1'b0, 3'b000); e_srd++;
        idle();
        chk_counts("R3");
        chk("R3", "err_sticky", int'(esticky), 0);
    endtask

    task automatic t_bursts();
        for (int i = 0; i < LEN - 1; i++) beat(1'b1, 1'b1, 1'b0, 3'b010);
        chk_counts("R4");
        beat(1'b1, 1'b1, 1'b0, 3'b111); e_brd++;
        chk_counts("R4");
        good_burst(1'b1);
        good_burst(1'b1);
        idle();
        chk_counts("R4");
        chk("R4", "err_sticky", int'(esticky), 0);
    endtask

    task automatic t_single_mid();
        beat(1'b1, 1'b1, 1'b0, 3'b010);
        beat(1'b1, 1'b1, 1'b1, 3'b000);
        chk("R5", "err_pulse", int'(epulse), 1);
        chk_counts("R5");
        good_burst(1'b0);
        chk("R5", "no err after resync", int'(epulse), 0);
        chk_counts("R5");
    endtask

    task automatic t_early_end();
        beat(1'b1, 1'b1, 1'b1, 3'b010);
        beat(1'b1, 1'b1, 1'b1, 3'b111);
        chk("R6", "err_pulse", int'(epulse), 1);
        chk_counts("R6");
        beat(1'b1, 1'b1, 1'b1, 3'b111);
        chk("R6", "err_pulse end at zero", int'(epulse), 1);
        good_burst(1'b1);
        chk("R6", "no err after resync", int'(epulse), 0);
        chk_counts("R6");
    endtask

    task automatic t_too_long();
        for (int i = 0; i < LEN - 1; i++) beat(1'b1, 1'b1, 1'b0, 3'b010);
        beat(1'b1, 1'b1, 1'b0, 3'b010);
        chk("R7", "err_pulse", int'(epulse), 1);
        chk_counts("R7");
        good_burst(1'b0);
        chk("R7", "no err after resync", int'(epulse), 0);
        chk_counts("R7");
    endtask

    task automatic t_unknown();
        idle();
        beat(1'b1, 1'b1, 1'b0, 3'b001);
        chk("R8", "err_pulse tag 001", int'(epulse), 1);
        beat(1'b1, 1'b1, 1'b1, 3'b010);
        beat(1'b1, 1'b1, 1'b1, 3'b011);
        chk("R8", "err_pulse tag 011", int'(epulse), 1);
        chk_counts("R8");
        good_burst(1'b1);
        chk("R8", "no err after resync", int'(epulse), 0);
        chk_counts("R8");
    endtask

    task automatic t_pulse();
        beat(1'b1, 1'b1, 1'b0, 3'b110);
        chk("R9", "err_pulse high", int'(epulse), 1);
        idle();
        chk("R9", "err_pulse drops", int'(epulse), 0);
        chk("R9", "err_sticky held", int'(esticky), 1);
        repeat (5) idle();
        chk("R9", "err_sticky still held", int'(esticky), 1);
    endtask

    task automatic t_saturate();
        @(negedge clk);
        cyc = 1'b1; ack = 1'b1; we = 1'b1; cti = 3'b000;
        repeat (65540) @(posedge clk);
        #1;
        e_swr = 65535;
        idle();
        chk("R10", "single_wr_cnt saturated", int'(swr), 65535);
        chk_counts("R10");
    endtask

    task automatic t_reset_again();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        @(negedge clk);
        rst = 1'b0;
        e_srd = 0; e_swr = 0; e_brd = 0; e_bwr = 0;
        chk_counts("R1");
        chk("R1", "err_sticky cleared", int'(esticky), 0);
        chk("R1", "err_pulse cleared", int'(epulse), 0);
        beat(1'b1, 1'b1, 1'b0, 3'b111);
        chk("R1", "position cleared (end at zero is error)", int'(epulse), 1);
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst = 1'b0;
        t_ignored();
        t_singles();
        t_bursts();
        t_single_mid();
        t_early_end();
        t_too_long();
        t_unknown();
        t_pulse();
        t_saturate();
        t_reset_again();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule